// File: doc/BRIEF.md
# Board Interrupt and Status Register Controller

This block collects sixteen external interrupt lines into one interrupt request for a host processor. It also holds a small set of general-purpose control and status words. The host reaches every register through a plain 32-bit register port: a byte offset, a write strobe, write data and read data. Reads are combinational from the offset. A write takes effect on the clock edge on which the strobe is high. The port has no handshake and never stalls, so it needs no back-pressure rules.

Each interrupt line first passes through a two-flop synchronizer. A synchronized rising edge on an enabled line sets that line's pending bit. The request output is high while any bit is both pending and enabled. Software can write the pending register directly, which lets it both set and clear bits. Two of the lines also report card presence in two socket status words. Each of those words has a five-bit field that software may write, an active-low card-detect bit and a ready flag.

Top module: `board_irq_ctrl`

## Requirements
- R1: After reset, both socket status words (offset 0xE0 for socket 0, 0xE4 for socket 1) read 0x0000_0420. Every other register reads zero, and `irq_out` is low.
- R2: The eight general-purpose words at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 store a full 32-bit write and return it on read.
- R3: A write to the enable register (0xC0) or to the pending register (0xD0) is ANDed with 0x000F_EEFF before it is stored. Bits 8, 12 and 20 to 31 of both registers therefore always read zero.
- R4: A write to the pending register replaces its whole contents with the masked data, so software can set bits as well as clear them.
- R5: A rising edge on input n while enable bit n is 1 sets pending bit n. The bit can be read three clock edges after the input rises. A level that stays high does not set the bit again after software has cleared it.
- R6: An input that rises while its enable bit is 0 leaves no pending bit, even if the bit is enabled later. An input that falls does not clear its pending bit.
- R7: `irq_out` is high exactly when the bitwise AND of the pending and enable registers is nonzero. It follows a write to either register in the same cycle that the register changes.
- R8: Bit 5 of socket 0 status is the inverse of input 9, and bit 5 of socket 1 status is the inverse of input 13 (0 means a card is present). Each follows its input three clock edges after the input changes.
- R9: A write to a socket status word changes only bits 4 to 0. Bit 10 (ready) stays 1, bit 5 keeps following its input, and all other bits stay zero.
- R10: A read of an offset outside the register map returns zero. A write to such an offset changes no register.
- R11: When a pending-register write and an enabled input edge fall on the same clock edge, the edge's bit ends up set and every other bit takes the masked write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, one write per high cycle |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 16 | Asynchronous interrupt lines, active high |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
A wrong pending or enable state shows at the ports in one of two ways: on the register port as soon as that register is read, or on `irq_out` in the same cycle that the faulty bit meets its partner. A fault in the synchronizer or in the edge detection shifts when a pending bit or a card-detect bit appears away from the third edge after the input change. The bench therefore samples both the cycle before that edge and the cycle after it. A fault in the write masks or in the socket write protection leaves bits that read back wrong right after the write that caused them.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned OFS_W    = 8;
  localparam int unsigned NUM_GP   = 8;

  // Write mask shared by the enable and pending registers.
  localparam logic [REG_W-1:0] IRQ_WMASK = 32'h000F_EEFF;

  localparam logic [OFS_W-1:0] OFS_ENABLE  = 8'hC0;
  localparam logic [OFS_W-1:0] OFS_PENDING = 8'hD0;
  localparam logic [OFS_W-1:0] OFS_SOCK0   = 8'hE0;
  localparam logic [OFS_W-1:0] OFS_SOCK1   = 8'hE4;

  // Socket status word layout.
  localparam int unsigned SOCK_CTL_W = 5;
  localparam int unsigned SOCK_CD    = 5;
  localparam int unsigned SOCK_RDY   = 10;

  // Interrupt lines that report card presence.
  localparam int unsigned SOCK0_LINE = 9;
  localparam int unsigned SOCK1_LINE = 13;

  // Byte offset of general-purpose word idx.
  function automatic logic [OFS_W-1:0] gp_offset(input int idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'h14;
      2:       return 8'h40;
      3:       return 8'h60;
      4:       return 8'h80;
      5:       return 8'h84;
      6:       return 8'h88;
      default: return 8'h90;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import board_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] level_i,
  input  logic                 en_wr_i,
  input  logic                 pend_wr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     enable_o,
  output logic [REG_W-1:0]     pending_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] level_q;
  logic [REG_W-1:0]     enable_q, pending_q, pending_d, set_vec;
  logic [NUM_LINES-1:0] rise;

  assign rise    = level_i & ~level_q;
  // The enable mask already clears the hole bits, so no input can set them.
  assign set_vec = REG_W'(rise) & enable_q;

  always_comb begin
    pending_d = pend_wr_i ? (wdata_i & IRQ_WMASK) : pending_q;
    pending_d = pending_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q   <= '0;
      enable_q  <= '0;
      pending_q <= '0;
    end else begin
      level_q   <= level_i;
      pending_q <= pending_d;
      if (en_wr_i) enable_q <= wdata_i & IRQ_WMASK;
    end
  end

  assign enable_o  = enable_q;
  assign pending_o = pending_q;
  assign irq_o     = |(pending_q & enable_q);
endmodule

// File: rtl/sock_status.sv
module sock_status
  import board_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             detect_i,
  output logic [REG_W-1:0] status_o
);
  logic [SOCK_CTL_W-1:0] ctl_q;
  logic                  cd_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      cd_n_q <= 1'b1;
    end else begin
      cd_n_q <= ~detect_i;
      if (wr_i) ctl_q <= wdata_i[SOCK_CTL_W-1:0];
    end
  end

  always_comb begin
    status_o                   = '0;
    status_o[SOCK_CTL_W-1:0]   = ctl_q;
    status_o[SOCK_CD]          = cd_n_q;
    status_o[SOCK_RDY]         = 1'b1;
  end
endmodule

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
  import board_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OFS_W-1:0]     bus_addr,
  input  logic                 bus_wr_en,
  input  logic [REG_W-1:0]     bus_wr_data,
  output logic [REG_W-1:0]     bus_rd_data,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0] line_sync;
  logic [REG_W-1:0]     enable_q, pending_q, sock0_stat, sock1_stat;
  logic [REG_W-1:0]     gp_q [NUM_GP];

  irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(irq_in), .sync_o(line_sync)
  );

  irq_pend_ctrl #(.NUM_LINES(NUM_LINES)) pend_i (
    .clk(clk), .rst_n(rst_n), .level_i(line_sync),
    .en_wr_i(bus_wr_en && bus_addr == OFS_ENABLE),
    .pend_wr_i(bus_wr_en && bus_addr == OFS_PENDING),
    .wdata_i(bus_wr_data), .enable_o(enable_q), .pending_o(pending_q),
    .irq_o(irq_out)
  );

  sock_status sock0_i (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_en && bus_addr == OFS_SOCK0),
    .wdata_i(bus_wr_data), .detect_i(line_sync[SOCK0_LINE]), .status_o(sock0_stat)
  );

  sock_status sock1_i (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_en && bus_addr == OFS_SOCK1),
    .wdata_i(bus_wr_data), .detect_i(line_sync[SOCK1_LINE]), .status_o(sock1_stat)
  );

  for (genvar g = 0; g < NUM_GP; g++) begin : gp_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    gp_q[g] <= '0;
      else if (bus_wr_en && bus_addr == gp_offset(g)) gp_q[g] <= bus_wr_data;
    end
  end

  always_comb begin
    bus_rd_data = '0;
    for (int i = 0; i < NUM_GP; i++)
      if (bus_addr == gp_offset(i)) bus_rd_data = gp_q[i];
    case (bus_addr)
      OFS_ENABLE:  bus_rd_data = enable_q;
      OFS_PENDING: bus_rd_data = pending_q;
      OFS_SOCK0:   bus_rd_data = sock0_stat;
      OFS_SOCK1:   bus_rd_data = sock1_stat;
      default:     ;
    endcase
  end
endmodule

module board_irq_ctrl_chk
  import board_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OFS_W-1:0] bus_addr,
  input logic             bus_wr_en,
  input logic [REG_W-1:0] enable_q,
  input logic [REG_W-1:0] pending_q,
  input logic [REG_W-1:0] sock0_stat,
  input logic [REG_W-1:0] sock1_stat,
  input logic [15:0]      line_sync
);
  logic wr_pend, wr_en;
  assign wr_pend = bus_wr_en && bus_addr == OFS_PENDING;
  assign wr_en   = bus_wr_en && bus_addr == OFS_ENABLE;

  // R3
  mask_holes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((enable_q | pending_q) & ~IRQ_WMASK) == '0);

  // R6
  no_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> (($past(pending_q) & ~pending_q) == '0));

  // R6
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pend && !wr_en) |=> ((pending_q & ~$past(pending_q) & ~$past(enable_q)) == '0));

  // R8
  card_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sock0_stat[SOCK_CD] == !$past(line_sync[SOCK0_LINE]) &&
              sock1_stat[SOCK_CD] == !$past(line_sync[SOCK1_LINE])));

  // R9
  sock_ctl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && bus_addr == OFS_SOCK0) |=> $stable(sock0_stat[SOCK_CTL_W-1:0]));

  // R9
  sock_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sock0_stat[SOCK_RDY] && sock1_stat[SOCK_RDY]);
endmodule

bind board_irq_ctrl board_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .enable_q(enable_q), .pending_q(pending_q), .sock0_stat(sock0_stat),
  .sock1_stat(sock1_stat), .line_sync(line_sync)
);

// File: tb/board_irq_ctrl_tb_top.sv
module board_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic [31:0] bus_rd_data;
  logic [15:0] irq_in = '0;
  logic        irq_out;
  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  board_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_en = 1'b1; bus_wr_data = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rd_data;
  endtask

  task automatic t_reset;
    rd(8'hE0, v); check("R1 sock0 reset", v, 32'h420);
    rd(8'hE4, v); check("R1 sock1 reset", v, 32'h420);
    rd(8'hC0, v); check("R1 enable reset", v, 0);
    rd(8'hD0, v); check("R1 pending reset", v, 0);
    rd(8'h84, v); check("R1 gp reset", v, 0);
    check("R1 irq_out reset", {31'b0, irq_out}, 0);
  endtask

  task automatic t_gp;
    logic [7:0] ofs [8] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};
    for (int i = 0; i < 8; i++) wr(ofs[i], 32'hA5C3_0000 ^ (32'h1111_1111 * i));
    for (int i = 0; i < 8; i++) begin
      rd(ofs[i], v);
      check("R2 gp readback", v, 32'hA5C3_0000 ^ (32'h1111_1111 * i));
    end
  endtask

  task automatic t_mask;
    wr(8'hC0, 32'hFFFF_FFFF); rd(8'hC0, v); check("R3 enable mask", v, 32'h000F_EEFF);
    check("R7 irq low, nothing pending", {31'b0, irq_out}, 0);
    wr(8'hD0, 32'hFFFF_FFFF); rd(8'hD0, v); check("R3 pending mask", v, 32'h000F_EEFF);
    check("R7 irq high", {31'b0, irq_out}, 1);
    wr(8'hC0, 0);
    check("R7 irq low after enable cleared", {31'b0, irq_out}, 0);
    wr(8'hD0, 0);
  endtask

  task automatic t_pend_write;
    wr(8'hD0, 32'h0000_0005); rd(8'hD0, v); check("R4 pending set by write", v, 5);
    check("R7 pending but disabled", {31'b0, irq_out}, 0);
    wr(8'hC0, 32'h4);
    check("R7 enable meets pending", {31'b0, irq_out}, 1);
    wr(8'hD0, 32'h1); rd(8'hD0, v); check("R4 pending replaced", v, 1);
    check("R7 irq drops after replace", {31'b0, irq_out}, 0);
    wr(8'hD0, 0); wr(8'hC0, 0);
  endtask

  task automatic t_edge;
    wr(8'hC0, 32'h8);
    irq_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'hD0, v); check("R5 not yet pending after two edges", v, 0);
    @(negedge clk);
    rd(8'hD0, v); check("R5 pending after three edges", v, 32'h8);
    check("R7 irq on edge", {31'b0, irq_out}, 1);
    wr(8'hD0, 0);
    repeat (5) @(negedge clk);
    rd(8'hD0, v); check("R5 held level does not re-set", v, 0);
    irq_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    irq_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'hD0, v); check("R5 new edge sets again", v, 32'h8);
    irq_in[3] = 1'b0;
    repeat (5) @(negedge clk);
    rd(8'hD0, v); check("R6 fall keeps pending", v, 32'h8);
    wr(8'hD0, 0); wr(8'hC0, 0);
  endtask

  task automatic t_disabled;
    irq_in[4] = 1'b1;
    repeat (5) @(negedge clk);
    wr(8'hC0, 32'h10);
    repeat (3) @(negedge clk);
    rd(8'hD0, v); check("R6 disabled edge leaves nothing", v, 0);
    check("R6 irq stays low", {31'b0, irq_out}, 0);
    irq_in[4] = 1'b0;
    wr(8'hC0, 0);
  endtask

  task automatic t_card;
    irq_in[9] = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'hE0, v); check("R8 sock0 cd not yet", v, 32'h420);
    @(negedge clk);
    rd(8'hE0, v); check("R8 sock0 card present", v, 32'h400);
    rd(8'hE4, v); check("R8 sock1 unaffected", v, 32'h420);
    irq_in[9] = 1'b0; irq_in[13] = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'hE0, v); check("R8 sock0 card removed", v, 32'h420);
    rd(8'hE4, v); check("R8 sock1 card present", v, 32'h400);
    irq_in[13] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_sock_wr;
    wr(8'hE0, 32'hFFFF_FFFF); rd(8'hE0, v); check("R9 sock0 write protect", v, 32'h43F);
    wr(8'hE4, 32'h0000_0412); rd(8'hE4, v); check("R9 sock1 low field", v, 32'h432);
    wr(8'hE0, 0); rd(8'hE0, v); check("R9 sock0 cleared field", v, 32'h420);
    wr(8'hE4, 0);
  endtask

  task automatic t_unmapped;
    wr(8'h40, 32'h1234_5678);
    wr(8'h44, 32'hDEAD_BEEF); rd(8'h44, v); check("R10 unmapped read zero", v, 0);
    wr(8'hE8, 32'hFFFF_FFFF); rd(8'hE8, v); check("R10 unmapped read zero 2", v, 0);
    rd(8'h40, v); check("R10 neighbour unchanged", v, 32'h1234_5678);
    rd(8'hE4, v); check("R10 sock1 unchanged", v, 32'h420);
    rd(8'hC0, v); check("R10 enable unchanged", v, 0);
  endtask

  task automatic t_collide;
    wr(8'hC0, 32'hC); wr(8'hD0, 32'h8);
    irq_in[2] = 1'b1;
    repeat (2) @(negedge clk);
    bus_addr = 8'hD0; bus_wr_en = 1'b1; bus_wr_data = 32'h0001_0000;
    @(negedge clk);
    bus_wr_en = 1'b0;
    rd(8'hD0, v); check("R11 edge wins over write", v, 32'h0001_0004);
    irq_in[2] = 1'b0;
    wr(8'hD0, 0); wr(8'hC0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gp();
    t_mask();
    t_pend_write();
    t_edge();
    t_disabled();
    t_card();
    t_sock_wr();
    t_unmapped();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule